// File: doc/BRIEF.md
# Packed Float-to-Integer Truncating Converter

This block turns one 128-bit vector of floating-point values into four 32-bit integers, rounding every lane toward zero. The operand holds either four single-precision lanes or two double-precision lanes. In double mode the two results fill the two lowest integer lanes and the upper 64 bits of the result are cleared. Each operation picks a signed or an unsigned destination.

Lanes that hold a NaN or a value whose truncation does not fit the destination are resolved by one of two selectable policies. The clamping policy pins the lane to the nearest destination bound and turns NaN into zero. The marker policy replaces the lane with one fixed pattern that depends only on signedness. The result is registered: an operand presented with `in_valid` high appears one clock later with `out_valid` high.

Top module: `pkd_trunc_cvt`

## Requirements
- R1: With `in_dbl`=0, bits [32k+31:32k] of `in_vec` are an IEEE single-precision value whose truncation toward zero appears in bits [32k+31:32k] of `out_vec`, for k = 0..3.
- R2: With `in_dbl`=1, bits [63:0] and [127:64] of `in_vec` are IEEE double-precision values converted into result bits [31:0] and [63:32], and bits [127:64] of `out_vec` are zero.
- R3: `in_signed`=1 selects the destination range [-2^31, 2^31-1]. `in_signed`=0 selects [0, 2^32-1]. In unsigned mode, a negative input whose truncation is 0 (above -1.0) is in range and gives 0.
- R4: With `in_sat`=1, a NaN lane gives 0. An out-of-range lane, infinities included, gives the upper bound when positive and the lower bound when negative (signed 0x7FFFFFFF / 0x80000000, unsigned 0xFFFFFFFF / 0x00000000).
- R5: With `in_sat`=0 and `in_signed`=1, every NaN or out-of-range lane gives 0x80000000.
- R6: With `in_sat`=0 and `in_signed`=0, every NaN or out-of-range lane gives 0xFFFFFFFF.
- R7: Positive and negative zero, denormals and every value with magnitude below 1.0 give 0 in every mode.
- R8: `out_valid` equals `in_valid` of the previous clock. While `rst_n` is low, `out_valid` and `out_vec` are 0.
- R9: When `in_valid` is 0, `out_vec` keeps its previous value on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand qualifier |
| in_vec | input | 128 | Packed floating-point operand |
| in_dbl | input | 1 | 1: two double lanes, 0: four single lanes |
| in_signed | input | 1 | 1: signed destination, 0: unsigned |
| in_sat | input | 1 | 1: clamp policy, 0: fixed-marker policy |
| out_valid | output | 1 | Result qualifier, one clock after `in_valid` |
| out_vec | output | 128 | Four packed 32-bit integer results |

## Verification
The conversion is pure per-lane logic feeding one register, so a wrong classification or shift appears on `out_vec` in the very next clock and is confined to the lane that caused it. Boundary operands show the faults that are most likely. A mis-set exponent threshold moves ±2^31 and 2^32 to the wrong side of the range check. A missing implicit one collapses small magnitudes. A mis-steered policy shows at once on NaN and infinity lanes. A hold or valid fault shows when `in_valid` drops and the result register changes, or when `out_valid` does not follow `in_valid`.

// File: rtl/fti_pkg.sv
package fti_pkg;
    localparam int LANE_W   = 32;
    localparam int VEC_W    = 128;
    localparam int N_SP     = VEC_W / LANE_W;
    localparam int DP_W     = 2 * LANE_W;
    localparam int N_DP     = VEC_W / DP_W;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } cvt_state_t;
endpackage

// File: rtl/fti_lane.sv
module fti_lane #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int OUT_W = 32
) (
    input  logic [EXP_W+MAN_W:0] fp_i,
    input  logic                 signed_i,
    input  logic                 sat_i,
    output logic [OUT_W-1:0]     int_o
);
    localparam int SH_W = $clog2(OUT_W);
    localparam int WIDE = MAN_W + 1 + OUT_W;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] BIAS_V = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] BIG_V  = EXP_W'(BIAS + OUT_W);
    localparam logic [OUT_W-1:0] SMIN   = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] SMAX   = ~SMIN;
    localparam logic [OUT_W-1:0] UMAX   = '1;

    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] man;
    logic             is_nan;
    logic             below_one;
    logic             too_big;
    logic [SH_W-1:0]  sh;
    logic [WIDE-1:0]  shifted;
    logic [OUT_W-1:0] mag;
    logic [OUT_W-1:0] in_val;
    logic [OUT_W-1:0] marker;
    logic             oor;

    assign sgn = fp_i[EXP_W+MAN_W];
    assign ex  = fp_i[EXP_W+MAN_W-1:MAN_W];
    assign man = fp_i[MAN_W-1:0];

    // classification of the exponent field
    assign is_nan    = (&ex) && (|man);
    assign below_one = ex < BIAS_V;
    assign too_big   = ex >= BIG_V;

    // integer magnitude: restore the hidden one, shift by unbiased exponent
    always_comb begin
        sh      = SH_W'(ex - BIAS_V);
        shifted = {{OUT_W{1'b0}}, 1'b1, man} << sh;
        mag     = shifted[MAN_W +: OUT_W];
    end

    // range test against the destination type
    always_comb begin
        if (too_big) begin
            oor = 1'b1;
        end else if (below_one) begin
            oor = 1'b0;
        end else if (signed_i) begin
            oor = sgn ? (mag > SMIN) : mag[OUT_W-1];
        end else begin
            oor = sgn;
        end
    end

    always_comb begin
        if (below_one) begin
            in_val = '0;
        end else if (signed_i && sgn) begin
            in_val = ~mag + 1'b1;
        end else begin
            in_val = mag;
        end
    end

    assign marker = signed_i ? SMIN : UMAX;

    // policy resolution
    always_comb begin
        if (is_nan) begin
            int_o = sat_i ? '0 : marker;
        end else if (oor) begin
            if (!sat_i) begin
                int_o = marker;
            end else if (sgn) begin
                int_o = signed_i ? SMIN : '0;
            end else begin
                int_o = signed_i ? SMAX : UMAX;
            end
        end else begin
            int_o = in_val;
        end
    end

    always_comb begin
        if (is_nan && sat_i) begin
            AST_NAN_CLAMP_ZERO: assert (int_o == '0);                          // R4
        end
        if (!sat_i && (is_nan || oor)) begin
            AST_MARKER_PATTERN: assert (int_o == (signed_i ? SMIN : UMAX));    // R5
        end
        if (below_one && !is_nan) begin
            AST_TINY_IS_ZERO: assert (int_o == '0);                            // R7
        end
    end
endmodule

// File: rtl/fti_pack.sv
module fti_pack #(
    parameter int LANE_W = 32,
    parameter int N_SP   = 4,
    parameter int N_DP   = 2
) (
    input  logic [N_SP*LANE_W-1:0] sp_i,
    input  logic [N_DP*LANE_W-1:0] dp_i,
    input  logic                   dbl_i,
    output logic [N_SP*LANE_W-1:0] vec_o
);
    for (genvar g = 0; g < N_SP; g++) begin : g_lane
        if (g < N_DP) begin : g_low
            assign vec_o[g*LANE_W +: LANE_W] =
                dbl_i ? dp_i[g*LANE_W +: LANE_W] : sp_i[g*LANE_W +: LANE_W];
        end else begin : g_high
            assign vec_o[g*LANE_W +: LANE_W] =
                dbl_i ? '0 : sp_i[g*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/pkd_trunc_cvt.sv
module pkd_trunc_cvt
    import fti_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] in_vec,
    input  logic             in_dbl,
    input  logic             in_signed,
    input  logic             in_sat,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec
);
    logic [N_SP*LANE_W-1:0] sp_res;
    logic [N_DP*LANE_W-1:0] dp_res;
    logic [VEC_W-1:0]       packed_res;
    cvt_state_t             st_d, st_q;

    for (genvar i = 0; i < N_SP; i++) begin : g_sp
        fti_lane #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W), .OUT_W(LANE_W)) i_lane (
            .fp_i     (in_vec[i*LANE_W +: LANE_W]),
            .signed_i (in_signed),
            .sat_i    (in_sat),
            .int_o    (sp_res[i*LANE_W +: LANE_W])
        );
    end

    for (genvar j = 0; j < N_DP; j++) begin : g_dp
        fti_lane #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W), .OUT_W(LANE_W)) i_lane (
            .fp_i     (in_vec[j*DP_W +: DP_W]),
            .signed_i (in_signed),
            .sat_i    (in_sat),
            .int_o    (dp_res[j*LANE_W +: LANE_W])
        );
    end

    fti_pack #(.LANE_W(LANE_W), .N_SP(N_SP), .N_DP(N_DP)) i_pack (
        .sp_i  (sp_res),
        .dp_i  (dp_res),
        .dbl_i (in_dbl),
        .vec_o (packed_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.vec = packed_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_vec   = st_q.vec;

    AST_VALID_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                               // R8
    AST_VALID_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                             // R8
    AST_DBL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dbl) |=> (out_vec[VEC_W-1:DP_W*(N_DP/2)] == '0));      // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_vec));                                       // R9
endmodule

// File: tb/test_pkd_trunc_cvt.sv
module test_pkd_trunc_cvt;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_vec = '0;
    logic         in_dbl = 1'b0;
    logic         in_signed = 1'b0;
    logic         in_sat = 1'b0;
    logic         out_valid;
    logic [127:0] out_vec;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    logic         exp_valid = 1'b0;
    logic [127:0] exp_vec = '0;
    string        exp_tag = "R8";

    always #5 clk = ~clk;

    pkd_trunc_cvt i_pkd_trunc_cvt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .in_dbl(in_dbl), .in_signed(in_signed), .in_sat(in_sat),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic real sp_to_real(logic [31:0] b);
        if (b[30:23] == 8'd0) return 0.0;
        if (b[30:23] == 8'hFF)
            return $bitstoreal({b[31], 11'h7FF, 52'd0});
        return $bitstoreal({b[31], 11'(b[30:23]) + 11'd896, b[22:0], 29'd0});
    endfunction

    function automatic logic [31:0] lane_ref(real r, bit nan, bit sgn, bit sat);
        real    t;
        longint v;
        bit     ok;
        if (nan) return sat ? 32'h0 : (sgn ? 32'h8000_0000 : 32'hFFFF_FFFF);
        ok = sgn ? (r > -2147483649.0 && r < 2147483648.0)
                 : (r > -1.0 && r < 4294967296.0);
        if (!ok) begin
            if (!sat) return sgn ? 32'h8000_0000 : 32'hFFFF_FFFF;
            if (sgn) return (r < 0.0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
            return (r < 0.0) ? 32'h0 : 32'hFFFF_FFFF;
        end
        t = (r < 0.0) ? $ceil(r) : $floor(r);
        v = longint'(t);
        return v[31:0];
    endfunction

    function automatic logic [127:0] vec_ref(logic [127:0] v, bit dbl, bit sgn, bit sat);
        logic [127:0] res = '0;
        if (dbl) begin
            for (int j = 0; j < 2; j++) begin
                logic [63:0] d = v[j*64 +: 64];
                bit nan = (d[62:52] == 11'h7FF) && (d[51:0] != 0);
                res[j*32 +: 32] = lane_ref($bitstoreal(d), nan, sgn, sat);
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                logic [31:0] s = v[i*32 +: 32];
                bit nan = (s[30:23] == 8'hFF) && (s[22:0] != 0);
                res[i*32 +: 32] = lane_ref(sp_to_real(s), nan, sgn, sat);
            end
        end
        return res;
    endfunction

    task automatic compare_now();
        n_cmp++;
        if (out_valid !== exp_valid || out_vec !== exp_vec) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b vec=%h, expected valid=%0b vec=%h",
                     exp_tag, out_valid, out_vec, exp_valid, exp_vec);
        end
    endtask

    task automatic step(bit vld, logic [127:0] v, bit dbl, bit sgn, bit sat, string tag);
        @(negedge clk);
        compare_now();
        in_valid  = vld;
        in_vec    = v;
        in_dbl    = dbl;
        in_signed = sgn;
        in_sat    = sat;
        exp_valid = vld;
        exp_tag   = tag;
        if (vld) exp_vec = vec_ref(v, dbl, sgn, sat);
    endtask

    function automatic string pol_tag(string base, bit sgn, bit sat);
        if (base != "R4") return base;
        if (sat) return "R4";
        return sgn ? "R5" : "R6";
    endfunction

    logic [31:0] sp_vals [16] = '{
        32'h3FC0_0000, 32'h42F7_CCCD, 32'hC2F7_CCCD, 32'h4049_0FDB,   // R1 plain values
        32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'hBF00_0000,   // R7 tiny values
        32'h4F00_0000, 32'hCF00_0000, 32'h4EFF_FFFF, 32'h4F7F_FFFF,   // R3 range edges
        32'h7FC0_0000, 32'h7F80_0000, 32'hFF80_0000, 32'h4F80_0000    // R4 specials
    };
    string sp_tags [4] = '{"R1", "R7", "R3", "R4"};

    logic [63:0] dp_vals [8] = '{
        64'h41DF_FFFF_FFE0_0000, 64'hC1E0_0000_0010_0000,
        64'hC1E0_0000_0020_0000, 64'h41EF_FFFF_FFF0_0000,
        64'h41F0_0000_0000_0000, 64'h7FF8_0000_0000_0000,
        64'hFFF0_0000_0000_0000, 64'h3FE8_0000_0000_0000
    };

    initial begin
        // reset state, R8
        repeat (3) begin
            @(negedge clk);
            compare_now();
        end
        rst_n = 1'b1;

        for (int c = 0; c < 4; c++) begin
            bit sgn = c[0];
            bit sat = c[1];
            for (int g = 0; g < 4; g++) begin
                step(1'b1, {sp_vals[g*4+3], sp_vals[g*4+2], sp_vals[g*4+1], sp_vals[g*4]},
                     1'b0, sgn, sat, pol_tag(sp_tags[g], sgn, sat));
            end
            for (int p = 0; p < 4; p++) begin
                step(1'b1, {dp_vals[p*2+1], dp_vals[p*2]}, 1'b1, sgn, sat, "R2");
            end
        end

        // idle cycles keep the result, R9; valid follows in_valid, R8
        step(1'b1, {4{32'h4120_0000}}, 1'b0, 1'b1, 1'b1, "R1");
        step(1'b0, {4{32'h7FC0_0000}}, 1'b0, 1'b0, 1'b0, "R9");
        step(1'b0, {2{64'h7FF0_0000_0000_0000}}, 1'b1, 1'b1, 1'b0, "R9");
        step(1'b1, {2{64'hBFEF_FFFF_FFFF_FFFF}}, 1'b1, 1'b0, 1'b0, "R7");
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, "R8");

        for (int k = 0; k < 200; k++) begin
            logic [127:0] rv = {$urandom, $urandom, $urandom, $urandom};
            bit dbl = $urandom % 2;
            if (k % 3 == 0) begin
                for (int i = 0; i < 4; i++) rv[i*32+23 +: 8] = 8'(8'd120 + ($urandom % 40));
            end
            step((k % 5) != 0, rv, dbl, $urandom % 2, $urandom % 2, dbl ? "R2" : "R1");
        end
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, "R9");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule